// File: doc/BRIEF.md
# Clock Multiplier Programming Register with Modulo Feedback Divider

This block holds the byte-wide setting for a clock multiplier loop and drives the programmable divider in its feedback path. The upper nibble of the byte selects the feedback multiplier N. The lower nibble selects the VCO range multiplier L. Software reads and writes the byte over a simple single-cycle bus at address 0x1E. The block also qualifies the loop's run and base-clock-select bits that come from a neighbouring control register. The VCO clock enters on its own pin and is divided by N to form the feedback clock for the phase comparator. That comparator, the oscillator and lock detection sit outside this block.

The divider is a two-state machine clocked by the VCO clock. In state `DV_HALT` the count is held at zero, the feedback output is low, and the terminal count is reloaded from the current effective N. The machine moves from `DV_HALT` to `DV_RUN` when the qualified loop enable rises, and it goes back from `DV_RUN` to `DV_HALT` as soon as that enable falls. In `DV_RUN` the count climbs to its terminal value (N minus one), raises the feedback output for one VCO cycle, wraps to zero, and loads a fresh terminal value only at that wrap.

Top module: `clkmul_prog`

## Requirements
- R1: After reset, a read at address 0x1E returns 0x66: multiplier nibble 6 in bits 7:4 and range nibble 6 in bits 3:0. `mult_n` and `range_l` both read 6.
- R2: When `pll_on` is 0, a write strobe at 0x1E stores `bus_wdata[7:4]` as the multiplier nibble and `bus_wdata[3:0]` as the range nibble. The next read at 0x1E returns the written byte.
- R3: A write strobe at any address other than 0x1E leaves both nibbles unchanged. A read at any other address returns 0x00.
- R4: `mult_n` is 1 when the multiplier nibble is 0. For any other nibble value it equals that value, so it is never 0.
- R5: While `pll_on` is 1, a write at 0x1E leaves the multiplier nibble at its old value.
- R6: While `pll_on` is 1, a write at 0x1E leaves the range nibble at its old value.
- R7: When the range nibble is 0, `pll_en` and `bcs_eff` are both 0. When it is nonzero, `pll_en` follows `pll_on` and `bcs_eff` follows `bcs_req`.
- R8: While `pll_en` is 1, `fb_clk` is high for exactly one VCO cycle in every N consecutive VCO cycles, with N = `mult_n`. For N = 1 it stays high.
- R9: While `pll_en` is 0, `fb_clk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pll_on | input | 1 | Loop-run bit from the control register |
| bcs_req | input | 1 | Base-clock-select bit from the control register |
| pll_en | output | 1 | Qualified loop enable |
| bcs_eff | output | 1 | Qualified base clock select |
| mult_n | output | 4 | Effective feedback multiplier N |
| range_l | output | 4 | VCO range multiplier L |
| vco_clk | input | 1 | VCO clock to be divided |
| vco_rst_n | input | 1 | Active-low asynchronous reset, VCO domain |
| fb_clk | output | 1 | Divided feedback clock |

## Verification
The bench walks every multiplier nibble from 0 to 15. For each one it counts the feedback highs in a window of four periods. A divider that treats nibble 0 as 0 would stall or run off, and one with an off-by-one terminal count would give the wrong number of highs. Writes attempted with the loop running must leave the readback unchanged; a design missing the lockout would show the new byte. A zero range nibble must hold both qualified outputs and the feedback clock low even with both request bits set; a design without that override would start the divider. Writes to a neighbouring address must leave the byte intact, and reads there must return zero.

// File: rtl/clkmul_prog_pkg.sv
package clkmul_prog_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int FIELD_W  = DATA_W / 2;
    localparam logic [ADDR_W-1:0] PROG_ADDR  = 8'h1E;
    localparam logic [DATA_W-1:0] PROG_RESET = 8'h66;

    typedef enum logic [0:0] {
        DV_HALT = 1'b0,
        DV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/clkmul_prog_regs.sv
module clkmul_prog_regs
    import clkmul_prog_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int FW = FIELD_W,
    parameter logic [AW-1:0] REG_ADDR = PROG_ADDR,
    parameter logic [2*FW-1:0] REG_RESET = PROG_RESET
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [2*FW-1:0] wdata,
    output logic [2*FW-1:0] rdata,
    input  logic            run_req,
    input  logic            bsel_req,
    output logic            run_ok,
    output logic            bsel_ok,
    output logic [FW-1:0]   n_eff,
    output logic [FW-1:0]   l_val
);

    localparam logic [FW-1:0] ONE = FW'(1);

    logic [FW-1:0] mul_q;
    logic [FW-1:0] rng_q;
    logic          hit;
    logic          wr_ok;
    logic          rng_zero;

    assign hit      = (addr == REG_ADDR);
    assign wr_ok    = we && hit && !run_req;
    assign rng_zero = (rng_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_q <= REG_RESET[2*FW-1:FW];
            rng_q <= REG_RESET[FW-1:0];
        end else if (wr_ok) begin
            mul_q <= wdata[2*FW-1:FW];
            rng_q <= wdata[FW-1:0];
        end
    end

    always_comb begin
        rdata   = hit ? {mul_q, rng_q} : '0;
        n_eff   = (mul_q == '0) ? ONE : mul_q;
        l_val   = rng_q;
        run_ok  = run_req && !rng_zero;
        bsel_ok = bsel_req && !rng_zero;
    end

    // R5
    mul_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit && run_req) |=> $stable(mul_q));

    // R6
    rng_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit && run_req) |=> $stable(rng_q));

    // R3
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit) |=> ($stable(mul_q) && $stable(rng_q)));

    // R4
    n_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        n_eff != '0);

endmodule

// File: rtl/clkmul_prog_fbdiv.sv
module clkmul_prog_fbdiv
    import clkmul_prog_pkg::*;
#(
    parameter int NW = FIELD_W
) (
    input  logic          vclk,
    input  logic          vrst_n,
    input  logic          enable,
    input  logic [NW-1:0] n_in,
    output logic          fb
);

    localparam logic [NW-1:0] ONE = NW'(1);

    div_state_e    state;
    div_state_e    nxt;
    logic [NW-1:0] cnt;
    logic [NW-1:0] term;
    logic          at_term;

    assign at_term = (cnt == term);

    always_ff @(posedge vclk or negedge vrst_n) begin
        if (!vrst_n) state <= DV_HALT;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            DV_HALT: if (enable)  nxt = DV_RUN;
            DV_RUN:  if (!enable) nxt = DV_HALT;
        endcase
    end

    always_ff @(posedge vclk or negedge vrst_n) begin
        if (!vrst_n) begin
            cnt  <= '0;
            term <= '0;
            fb   <= 1'b0;
        end else if (nxt == DV_HALT) begin
            cnt  <= '0;
            term <= n_in - ONE;
            fb   <= 1'b0;
        end else if (state == DV_HALT) begin
            cnt  <= '0;
            term <= n_in - ONE;
            fb   <= 1'b0;
        end else if (at_term) begin
            cnt  <= '0;
            term <= n_in - ONE;
            fb   <= 1'b1;
        end else begin
            cnt  <= cnt + ONE;
            fb   <= 1'b0;
        end
    end

    // R9
    halt_quiet_chk: assert property (@(posedge vclk) disable iff (!vrst_n)
        !enable |=> !fb);

    // R8
    cnt_bound_chk: assert property (@(posedge vclk) disable iff (!vrst_n)
        cnt <= term);

    // R8
    term_hold_chk: assert property (@(posedge vclk) disable iff (!vrst_n)
        (state == DV_RUN && nxt == DV_RUN && !at_term) |=> $stable(term));

    // R8
    pulse_wrap_chk: assert property (@(posedge vclk) disable iff (!vrst_n)
        (state == DV_RUN && nxt == DV_RUN && !at_term) |=> !fb);

endmodule

// File: rtl/clkmul_prog.sv
module clkmul_prog
    import clkmul_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pll_on,
    input  logic              bcs_req,
    output logic              pll_en,
    output logic              bcs_eff,
    output logic [FIELD_W-1:0] mult_n,
    output logic [FIELD_W-1:0] range_l,
    input  logic              vco_clk,
    input  logic              vco_rst_n,
    output logic              fb_clk
);

    clkmul_prog_regs #(
        .AW       (ADDR_W),
        .FW       (FIELD_W),
        .REG_ADDR (PROG_ADDR),
        .REG_RESET(PROG_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .run_req (pll_on),
        .bsel_req(bcs_req),
        .run_ok  (pll_en),
        .bsel_ok (bcs_eff),
        .n_eff   (mult_n),
        .l_val   (range_l)
    );

    clkmul_prog_fbdiv #(
        .NW(FIELD_W)
    ) u_fbdiv (
        .vclk  (vco_clk),
        .vrst_n(vco_rst_n),
        .enable(pll_en),
        .n_in  (mult_n),
        .fb    (fb_clk)
    );

    // R7
    range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (range_l == '0) |-> (!pll_en && !bcs_eff));

endmodule

// File: tb/clkmul_prog_test.sv
module clkmul_prog_test;

    logic       clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pll_on = 1'b0;
    logic       bcs_req = 1'b0;
    logic       pll_en;
    logic       bcs_eff;
    logic [3:0] mult_n;
    logic [3:0] range_l;
    logic       fb_clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;
    always #5  vco_clk = ~vco_clk;

    clkmul_prog uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_on(pll_on),
        .bcs_req(bcs_req), .pll_en(pll_en), .bcs_eff(bcs_eff),
        .mult_n(mult_n), .range_l(range_l), .vco_clk(vco_clk),
        .vco_rst_n(rst_n), .fb_clk(fb_clk)
    );

    // {write byte, 4'h0, expected N}
    localparam logic [15:0] VEC [16] = '{
        16'h0101, 16'h1201, 16'h2302, 16'h3403,
        16'h4504, 16'h5605, 16'h6706, 16'h7107,
        16'h8208, 16'h9309, 16'hA40A, 16'hB50B,
        16'hC60C, 16'hD70D, 16'hE10E, 16'hF20F
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h1E;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic count_highs(input int win, output int highs);
        highs = 0;
        repeat (6) @(negedge vco_clk);
        for (int i = 0; i < win; i++) begin
            @(negedge vco_clk);
            if (fb_clk) highs++;
        end
    endtask

    initial begin
        logic [7:0] rd;
        int h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset value
        bus_read(8'h1E, rd);
        check("R1 rdata", rd, 8'h66);
        check("R1 mult_n", mult_n, 6);
        check("R1 range_l", range_l, 6);

        // R3 write elsewhere ignored, read elsewhere zero
        bus_write(8'h1F, 8'h00);
        bus_write(8'h1D, 8'hFF);
        bus_read(8'h1E, rd);
        check("R3 byte kept", rd, 8'h66);
        bus_read(8'h1F, rd);
        check("R3 other read", rd, 8'h00);

        // R2 R4 R8 table walk
        for (int v = 0; v < 16; v++) begin
            pll_on = 1'b0;
            bus_write(8'h1E, VEC[v][15:8]);
            bus_read(8'h1E, rd);
            check("R2 readback", rd, VEC[v][15:8]);
            check("R4 mult_n", mult_n, VEC[v][3:0]);
            pll_on = 1'b1;
            count_highs(4 * VEC[v][3:0], h);
            check("R8 highs per 4N", h, 4);
            pll_on = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R9 divider quiet with loop off
        count_highs(40, h);
        check("R9 fb low when off", h, 0);

        // R5 R6 lockout
        bus_write(8'h1E, 8'h5A);
        pll_on = 1'b1;
        bus_write(8'h1E, 8'h03);
        bus_read(8'h1E, rd);
        check("R5 mult nibble locked", rd[7:4], 4'h5);
        check("R6 range nibble locked", rd[3:0], 4'hA);
        check("R5 mult_n locked", mult_n, 5);

        // R7 positive qualification
        bcs_req = 1'b1;
        @(negedge clk);
        check("R7 pll_en follows", pll_en, 1);
        check("R7 bcs_eff follows", bcs_eff, 1);

        // R7 R9 zero range override
        pll_on = 1'b0;
        bus_write(8'h1E, 8'h40);
        pll_on = 1'b1;
        @(negedge clk);
        check("R7 pll_en forced low", pll_en, 0);
        check("R7 bcs_eff forced low", bcs_eff, 0);
        count_highs(40, h);
        check("R9 fb low on zero range", h, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule